// File: doc/BRIEF.md
# Register Transfer Execution Unit

This unit carries out the inherent register-to-register moves of a small 8-bit processor core. The core holds an 8-bit accumulator, a 16-bit index pair (high byte H, low byte X), a 16-bit stack pointer and an 8-bit condition-code register. When an opcode is presented with `op_valid`, the unit decodes it, commits the move to its register file at that clock edge, and reports the instruction's cycle count one cycle later.

Six moves are supported:

- accumulator to condition codes, and condition codes to accumulator;
- accumulator to X, and X to accumulator;
- stack pointer to index pair, with an increment, so that the index pair points at the last byte pushed;
- index pair to stack pointer, with a decrement.

Any other opcode is flagged as illegal and has no effect. A load port lets the surrounding datapath write the accumulator, the index pair or the stack pointer. The rest of the core uses this port to deliver results from its other instructions.

The condition-code register keeps six flags:

| Bit | Flag |
|-----|------|
| 7 | V |
| 4 | H |
| 3 | I |
| 2 | N |
| 1 | Z |
| 0 | C |

Bits 6 and 5 always read as 1.

Top module: `xfer_exec_unit`

## Requirements
- R1: After reset, the outputs are as follows: `reg_a` is 0x00, `reg_hx` is 0x0000, `reg_sp` is SP_RESET (default 0x00FF), `reg_ccr` is 0x68 (I set, bits 6 and 5 read as 1), and `done`, `illegal` and `cycles` are 0.
- R2: Opcode 0x84 copies the accumulator into the condition codes. Afterwards `reg_ccr` equals A with bits 6 and 5 forced to 1, `cycles` reports 2, and no other register changes.
- R3: Opcode 0x85 copies the condition codes into the accumulator. Afterwards `reg_a` equals the previous `reg_ccr`, the flags are unchanged, and `cycles` reports 1.
- R4: Opcode 0x97 copies A into X. Afterwards `reg_hx[7:0]` equals A, `reg_hx[15:8]` (H) is unchanged, the flags are unchanged, and `cycles` reports 1.
- R5: Opcode 0x9F copies X into A. Afterwards `reg_a` equals the previous `reg_hx[7:0]`, the flags are unchanged, and `cycles` reports 1.
- R6: Opcode 0x95 sets `reg_hx` to `reg_sp` + 1 modulo 2^16, so 0xFFFF becomes 0x0000. `cycles` reports 2.
- R7: Opcode 0x94 sets `reg_sp` to `reg_hx` - 1 modulo 2^16, so 0x0000 becomes 0xFFFF. `cycles` reports 2.
- R8: Any opcode other than 0x84, 0x85, 0x94, 0x95, 0x97 or 0x9F leaves every register unchanged. It raises `illegal` for one cycle, with `cycles` at 0.
- R9: When `ld_valid` is high, `ld_data` is written to one target chosen by `ld_sel`: 0 selects A (low byte), 1 selects H:X, 2 selects SP, and 3 writes nothing. In that cycle `op_valid` is ignored and no instruction executes.
- R10: `done` is high for exactly the one cycle after an instruction is accepted. That is the same cycle in which its register result, `cycles` and `illegal` appear. Otherwise `done` is low and `illegal` and `cycles` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Execute `opcode` at this edge |
| opcode | input | 8 | Instruction opcode |
| ld_valid | input | 1 | Write `ld_data` into the register chosen by `ld_sel` |
| ld_sel | input | 2 | Load target: 0 A, 1 H:X, 2 SP, 3 none |
| ld_data | input | 16 | Load value (A takes the low byte) |
| reg_a | output | 8 | Accumulator |
| reg_hx | output | 16 | Index pair H:X |
| reg_sp | output | 16 | Stack pointer |
| reg_ccr | output | 8 | Condition codes, bits 6 and 5 read as 1 |
| done | output | 1 | An instruction finished in the previous cycle |
| illegal | output | 1 | The finished opcode was not recognised |
| cycles | output | 4 | Cycle count of the finished instruction |

## Verification
The bench builds the unit with its default parameters: an 8-bit accumulator, a 16-bit index pair and stack pointer, and SP_RESET at 0x00FF. At these widths all 256 accumulator values can be swept through both condition-code moves and both X moves, and all 256 opcode values can be swept against a fixed register state to show that only six opcodes have an effect. The 16-bit increment and decrement are driven across both wrap points and a strided set of values between them. The bench also checks that the load port blocks instruction execution and that select 3 writes nothing.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int DW    = 8;
  localparam int AW    = 2 * DW;
  localparam int CYC_W = 4;

  localparam logic [DW-1:0] OPC_TAP = 8'h84;
  localparam logic [DW-1:0] OPC_TPA = 8'h85;
  localparam logic [DW-1:0] OPC_TXS = 8'h94;
  localparam logic [DW-1:0] OPC_TSX = 8'h95;
  localparam logic [DW-1:0] OPC_TAX = 8'h97;
  localparam logic [DW-1:0] OPC_TXA = 8'h9F;

  typedef enum logic [2:0] {
    K_NONE, K_A2C, K_C2A, K_A2X, K_X2A, K_S2I, K_I2S
  } xfer_kind_e;

  // Six stored flags {V,H,I,N,Z,C} expanded to the 8-bit view.
  function automatic logic [DW-1:0] flags_to_byte(input logic [5:0] f);
    return {f[5], 2'b11, f[4:0]};
  endfunction

  // Byte into stored flags: bits 6 and 5 are dropped.
  function automatic logic [5:0] byte_to_flags(input logic [DW-1:0] b);
    return {b[7], b[4:0]};
  endfunction

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] v);
    return v + AW'(1);
  endfunction

  function automatic logic [AW-1:0] wrap_dec(input logic [AW-1:0] v);
    return v - AW'(1);
  endfunction
endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
  import xfer_pkg::*;
(
  input  logic [DW-1:0]    opcode,
  output xfer_kind_e       kind,
  output logic [CYC_W-1:0] cyc,
  output logic             bad
);
  always_comb begin
    kind = K_NONE;
    cyc  = '0;
    bad  = 1'b0;
    case (opcode)
      OPC_TAP: begin kind = K_A2C; cyc = CYC_W'(2); end
      OPC_TPA: begin kind = K_C2A; cyc = CYC_W'(1); end
      OPC_TAX: begin kind = K_A2X; cyc = CYC_W'(1); end
      OPC_TXA: begin kind = K_X2A; cyc = CYC_W'(1); end
      OPC_TSX: begin kind = K_S2I; cyc = CYC_W'(2); end
      OPC_TXS: begin kind = K_I2S; cyc = CYC_W'(2); end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
(
  input  xfer_kind_e    kind,
  input  logic [DW-1:0] a_q,
  input  logic [AW-1:0] hx_q,
  input  logic [AW-1:0] sp_q,
  input  logic [5:0]    fl_q,
  output logic [DW-1:0] a_d,
  output logic [AW-1:0] hx_d,
  output logic [AW-1:0] sp_d,
  output logic [5:0]    fl_d
);
  always_comb begin
    a_d  = a_q;
    hx_d = hx_q;
    sp_d = sp_q;
    fl_d = fl_q;
    case (kind)
      K_A2C: fl_d = byte_to_flags(a_q);
      K_C2A: a_d  = flags_to_byte(fl_q);
      K_A2X: hx_d = {hx_q[AW-1:DW], a_q};
      K_X2A: a_d  = hx_q[DW-1:0];
      K_S2I: hx_d = wrap_inc(sp_q);
      K_I2S: sp_d = wrap_dec(hx_q);
      default: ;
    endcase
  end
endmodule

// File: rtl/xfer_exec_unit.sv
module xfer_exec_unit
  import xfer_pkg::*;
#(
  parameter logic [15:0] SP_RESET = 16'h00FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [7:0]       opcode,
  input  logic             ld_valid,
  input  logic [1:0]       ld_sel,
  input  logic [15:0]      ld_data,
  output logic [7:0]       reg_a,
  output logic [15:0]      reg_hx,
  output logic [15:0]      reg_sp,
  output logic [7:0]       reg_ccr,
  output logic             done,
  output logic             illegal,
  output logic [3:0]       cycles
);
  localparam logic [5:0] FLAGS_RESET = 6'b001000; // only I set

  logic [DW-1:0]    a_q, a_d;
  logic [AW-1:0]    hx_q, hx_d, sp_q, sp_d;
  logic [5:0]       fl_q, fl_d;
  xfer_kind_e       dec_kind;
  logic [CYC_W-1:0] dec_cyc;
  logic             dec_bad;

  // Named events for the checker.
  logic accept;
  logic load_hit;
  assign accept   = op_valid & ~ld_valid;
  assign load_hit = ld_valid;

  xfer_decode u_dec (
    .opcode (opcode),
    .kind   (dec_kind),
    .cyc    (dec_cyc),
    .bad    (dec_bad)
  );

  xfer_datapath u_dp (
    .kind (dec_kind),
    .a_q  (a_q),
    .hx_q (hx_q),
    .sp_q (sp_q),
    .fl_q (fl_q),
    .a_d  (a_d),
    .hx_d (hx_d),
    .sp_d (sp_d),
    .fl_d (fl_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q     <= '0;
      hx_q    <= '0;
      sp_q    <= SP_RESET;
      fl_q    <= FLAGS_RESET;
      done    <= 1'b0;
      illegal <= 1'b0;
      cycles  <= '0;
    end else begin
      done    <= accept;
      illegal <= accept & dec_bad;
      cycles  <= accept ? dec_cyc : '0;
      if (load_hit) begin
        case (ld_sel)
          2'd0:    a_q  <= ld_data[DW-1:0];
          2'd1:    hx_q <= ld_data;
          2'd2:    sp_q <= ld_data;
          default: ;
        endcase
      end else if (accept) begin
        a_q  <= a_d;
        hx_q <= hx_d;
        sp_q <= sp_d;
        fl_q <= fl_d;
      end
    end
  end

  assign reg_a   = a_q;
  assign reg_hx  = hx_q;
  assign reg_sp  = sp_q;
  assign reg_ccr = flags_to_byte(fl_q);
endmodule

// File: rtl/xfer_exec_checker.sv
module xfer_exec_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        load_hit,
  input logic [7:0]  opcode,
  input logic [7:0]  reg_a,
  input logic [15:0] reg_hx,
  input logic [15:0] reg_sp,
  input logic [7:0]  reg_ccr,
  input logic        done,
  input logic        illegal,
  input logic [3:0]  cycles
);
  logic known;
  assign known = (opcode == 8'h84) || (opcode == 8'h85) || (opcode == 8'h94) ||
                 (opcode == 8'h95) || (opcode == 8'h97) || (opcode == 8'h9F);

  p_ccr_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_ccr[6:5] == 2'b11);

  p_a2c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && opcode == 8'h84) |=> (reg_ccr == ($past(reg_a) | 8'h60)) && $stable(reg_a));

  p_a2x_keeps_h_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && opcode == 8'h97) |=> (reg_hx[7:0] == $past(reg_a)) && $stable(reg_hx[15:8]) && $stable(reg_ccr));

  p_s2i_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && opcode == 8'h95) |=> reg_hx == 16'($past(reg_sp) + 16'd1));

  p_i2s_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && opcode == 8'h94) |=> reg_sp == 16'($past(reg_hx) - 16'd1));

  p_bad_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !known) |=> illegal && $stable(reg_a) && $stable(reg_hx) && $stable(reg_sp) && $stable(reg_ccr));

  p_load_blocks_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_hit |=> !done);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!illegal && cycles == 4'd0));
endmodule

bind xfer_exec_unit xfer_exec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .load_hit(load_hit),
  .opcode(opcode), .reg_a(reg_a), .reg_hx(reg_hx), .reg_sp(reg_sp),
  .reg_ccr(reg_ccr), .done(done), .illegal(illegal), .cycles(cycles)
);

// File: tb/xfer_exec_unit_test.sv
module xfer_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        ld_valid = 1'b0;
  logic [1:0]  ld_sel = 2'd0;
  logic [15:0] ld_data = 16'h0000;
  logic [7:0]  reg_a, reg_ccr;
  logic [15:0] reg_hx, reg_sp;
  logic        done, illegal;
  logic [3:0]  cycles;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  xfer_exec_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_data(ld_data),
    .reg_a(reg_a), .reg_hx(reg_hx), .reg_sp(reg_sp), .reg_ccr(reg_ccr),
    .done(done), .illegal(illegal), .cycles(cycles)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = sel; ld_data = val;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic exec(input logic [7:0] op);
    @(negedge clk);
    op_valid = 1'b1; opcode = op;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  ea, eccr;
    logic [15:0] ehx, esp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 a", 16'(reg_a), 16'h00);
    chk("R1 hx", reg_hx, 16'h0000);
    chk("R1 sp", reg_sp, 16'h00FF);
    chk("R1 ccr", 16'(reg_ccr), 16'h68);
    chk("R1 done", 16'(done), 16'h0);
    chk("R1 ill_cyc", {illegal, cycles}, 5'h0);

    // R2 / R3: every accumulator value through flags and back
    for (int v = 0; v < 256; v++) begin
      load(2'd0, 16'(v));
      exec(8'h84);
      eccr = 8'(v) | 8'h60;
      chk("R2 ccr", 16'(reg_ccr), 16'(eccr));
      chk("R2 cyc", 16'(cycles), 16'd2);
      chk("R2 a_kept", 16'(reg_a), 16'(v));
      chk("R10 done", 16'(done), 16'd1);
      load(2'd0, 16'h00);
      exec(8'h85);
      chk("R3 a", 16'(reg_a), 16'(eccr));
      chk("R3 ccr_kept", 16'(reg_ccr), 16'(eccr));
      chk("R3 cyc", 16'(cycles), 16'd1);
    end

    // R4 / R5: every value into X with H kept, then back to A
    for (int v = 0; v < 256; v++) begin
      ehx = {8'(255 - v), 8'h5A};
      load(2'd1, ehx);
      load(2'd0, 16'(v));
      eccr = reg_ccr;
      exec(8'h97);
      chk("R4 hx", reg_hx, {ehx[15:8], 8'(v)});
      chk("R4 ccr", 16'(reg_ccr), 16'(eccr));
      chk("R4 cyc", 16'(cycles), 16'd1);
      load(2'd1, {8'(v), 8'(v ^ 8'hC3)});
      exec(8'h9F);
      chk("R5 a", 16'(reg_a), 16'(8'(v ^ 8'hC3)));
      chk("R5 cyc", 16'(cycles), 16'd1);
    end

    // R6 / R7: strided 16-bit sweep including both wrap points
    for (int i = 0; i < 300; i++) begin
      logic [15:0] s;
      s = (i == 0) ? 16'hFFFF : (i == 1) ? 16'h0000 : 16'(i * 16'd223 + 16'd7);
      load(2'd2, s);
      exec(8'h95);
      chk("R6 hx", reg_hx, 16'(s + 17'd1));
      chk("R6 cyc", 16'(cycles), 16'd2);
      load(2'd1, s);
      exec(8'h94);
      chk("R7 sp", reg_sp, 16'(s + 17'h1FFFF));
      chk("R7 cyc", 16'(cycles), 16'd2);
    end

    // R8: every opcode value against a fixed state
    load(2'd0, 16'h3C);
    load(2'd1, 16'h1234);
    load(2'd2, 16'h8001);
    for (int op = 0; op < 256; op++) begin
      logic known;
      known = (op == 8'h84) || (op == 8'h85) || (op == 8'h94) ||
              (op == 8'h95) || (op == 8'h97) || (op == 8'h9F);
      if (!known) begin
        ea = reg_a; ehx = reg_hx; esp = reg_sp; eccr = reg_ccr;
        exec(8'(op));
        chk("R8 illegal", 16'(illegal), 16'd1);
        chk("R8 cyc", 16'(cycles), 16'd0);
        chk("R8 regs_a", 16'(reg_a), 16'(ea));
        chk("R8 regs_hx", reg_hx, ehx);
        chk("R8 regs_sp", reg_sp, esp);
        chk("R8 regs_ccr", 16'(reg_ccr), 16'(eccr));
      end
    end

    // R9: select 3 writes nothing; load blocks a simultaneous op
    ea = reg_a; ehx = reg_hx; esp = reg_sp;
    load(2'd3, 16'hBEEF);
    chk("R9 sel3_a", 16'(reg_a), 16'(ea));
    chk("R9 sel3_hx", reg_hx, ehx);
    chk("R9 sel3_sp", reg_sp, esp);
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = 2'd2; ld_data = 16'h4444;
    op_valid = 1'b1; opcode = 8'h95;
    @(negedge clk);
    ld_valid = 1'b0; op_valid = 1'b0;
    chk("R9 sp_loaded", reg_sp, 16'h4444);
    chk("R9 hx_untouched", reg_hx, ehx);
    chk("R9 no_done", 16'(done), 16'd0);

    // R10: done drops when idle
    @(negedge clk);
    chk("R10 idle_done", 16'(done), 16'd0);
    chk("R10 idle_cyc", {illegal, cycles}, 5'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule